// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block gathers up to 32 interrupt inputs and drives two active-low request lines toward a processor core: a prioritized normal line `irq_n` and a separate fast line `fiq_n` that belongs to source 0 alone. Each source has a mode register that sets its 3-bit priority and its trigger mode, and a vector register that holds its handler address. Software works through a small word-addressed register bus with one cycle of read latency.

Software takes a normal interrupt by reading the vector register. That read returns the winning handler address and pushes the winner's level onto an 8-entry hardware stack. While a level is on the stack, only a strictly higher level may raise `irq_n` again, so handlers can nest. Writing the end-of-interrupt register pops the level. If nothing is eligible at the moment of the read, the block returns a programmable spurious vector, does not push, and marks the case so that the matching end-of-interrupt leaves the stack untouched. Masks change through separate set and clear command registers, so no read-modify-write is needed. A force register makes any source pending for test.

Top module: `vnic_top`

Register map (word addresses): 0x00+n mode of source n (bits [2:0] priority, 7 highest; bit 3 edge trigger; bit 4 active-low, kept only for external sources); 0x20+n vector of source n; 0x40 normal vector read (acknowledge); 0x41 fast vector read (returns the vector of source 0); 0x42 current source (source on top of stack, 0 when empty); 0x43 pending; 0x44 mask; 0x45 mask set command; 0x46 mask clear command; 0x47 force set; 0x48 force clear; 0x49 end of interrupt; 0x4A spurious vector; 0x4B flags (bit 0 last read spurious, bit 1 normal request active, bit 2 fast request active).

## Requirements
- R1: After reset `irq_n` and `fiq_n` are high, and the mask (0x44), pending (0x43), current source (0x42) and flag (0x4B) registers all read 0.
- R2: A write to 0x45 sets each mask bit whose data bit is 1, a write to 0x46 clears each mask bit whose data bit is 1, and bits written as 0 leave their mask bits unchanged.
- R3: Source 0, when pending and enabled, drives `fiq_n` low and never `irq_n`; a read of 0x41 returns the vector of source 0.
- R4: Among enabled pending sources 1..N-1 the highest priority wins, ties go to the lowest source number, and a read of 0x40 returns the winner's vector.
- R5: After a read of 0x40 pushes a level, `irq_n` is driven low only by a source of strictly higher priority; a write to 0x49 pops the level and lets equal levels request again.
- R6: Register 0x42 returns the source number on top of the stack and 0 when the stack is empty.
- R7: Mode bit 3 = 0 makes a source level-sensitive (pending while the input is at its active level); bit 3 = 1 latches an edge (rising, or falling when bit 4 = 1), which stays pending after the input returns and clears when its vector is read.
- R8: For internal sources (1..23 by default) mode bit 4 is stored as 0 and reads back 0; for external sources (0 and 24..31) bit 4 = 1 selects active-low level or falling edge.
- R9: A read of 0x40 with no eligible source returns the spurious vector (0x4A), pushes nothing and sets flag bit 0; the next write to 0x49 clears the flag without popping.
- R10: A write to 0x47 makes each source with a 1 bit pending regardless of its input; a write to 0x48, or reading that source's vector, removes the forced state.
- R11: A write to 0x49 with an empty stack and no spurious flag has no effect.
- R12: The two request outputs are registered; a level change on an enabled input reaches `irq_n` or `fiq_n` within four clock cycles through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Raw interrupt inputs, asynchronous |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after the request |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
Random rounds program random priorities on the internal sources, enable a random subset and drive a random set of inputs high; the vector read is compared with a bench model of the selection rule, which separates priority ordering, tie-breaking by source number and mask filtering, and an empty eligible set must yield the spurious vector. A directed nesting sequence raises an equal-priority and then a higher-priority source during service, which separates strict from non-strict preemption, and places a spurious read inside a nested level so that a wrongful pop shows up in the current-source register. Short pulses, inverted inputs and forced bits tell latched edges from levels, the polarity choices from each other, and forced pending from input-driven pending.

// File: rtl/vnic_pkg.sv
package vnic_pkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_MODE_BASE = 7'h00;
  localparam logic [ADDR_W-1:0] A_VEC_BASE  = 7'h20;
  localparam logic [ADDR_W-1:0] A_IVR       = 7'h40;
  localparam logic [ADDR_W-1:0] A_FVR       = 7'h41;
  localparam logic [ADDR_W-1:0] A_STAT      = 7'h42;
  localparam logic [ADDR_W-1:0] A_PEND      = 7'h43;
  localparam logic [ADDR_W-1:0] A_MASK      = 7'h44;
  localparam logic [ADDR_W-1:0] A_EN        = 7'h45;
  localparam logic [ADDR_W-1:0] A_DIS       = 7'h46;
  localparam logic [ADDR_W-1:0] A_FSET      = 7'h47;
  localparam logic [ADDR_W-1:0] A_FCLR      = 7'h48;
  localparam logic [ADDR_W-1:0] A_EOI       = 7'h49;
  localparam logic [ADDR_W-1:0] A_SPUR      = 7'h4A;
  localparam logic [ADDR_W-1:0] A_FLAG      = 7'h4B;

  // mode register layout
  localparam int MODE_W   = 5;
  localparam int M_EDGE   = 3;
  localparam int M_LOW    = 4;
endpackage

// File: rtl/vnic_src_cond.sv
module vnic_src_cond #(
  parameter bit IS_EXT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  input  logic edge_mode,
  input  logic low_pol,
  input  logic ack,
  input  logic fset,
  input  logic fclr,
  output logic pend
);
  logic s1_q, s2_q, prev_q, edge_q, frc_q;
  logic lvl, rise, fall, det;
  logic pol;

  assign pol  = low_pol & IS_EXT;
  assign lvl  = s2_q ^ pol;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
  assign det  = pol ? fall : rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      s1_q   <= raw_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (!edge_mode)
        edge_q <= 1'b0;
      else if (det)
        edge_q <= 1'b1;
      else if (ack)
        edge_q <= 1'b0;
      if (fset)
        frc_q <= 1'b1;
      else if (fclr || ack)
        frc_q <= 1'b0;
    end
  end

  assign pend = (edge_mode ? edge_q : lvl) | frc_q;

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && $past(edge_mode) && $past(edge_q) && !$past(ack)) |-> edge_q);
endmodule

// File: rtl/vnic_prio_enc.sv
module vnic_prio_enc #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      active,
  input  logic [NSRC*PW-1:0]   prio_flat,
  output logic                 win_valid,
  output logic [IDXW-1:0]      win_idx,
  output logic [PW-1:0]        win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!win_valid || prio_flat[i*PW +: PW] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_prio  = prio_flat[i*PW +: PW];
      end
    end
  end

  // R4
  win_active_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> active[win_idx]);
  // R4
  win_none_chk: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |-> !win_valid);
endmodule

// File: rtl/vnic_stack.sv
module vnic_stack #(
  parameter int DEPTH = 8,
  parameter int EW    = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] top,
  output logic [CW-1:0] depth,
  output logic          empty,
  output logic          full
);
  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PTRW-1:0] top_ix, wr_ix;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign top_ix = PTRW'(cnt_q - 1'b1);
  assign wr_ix  = PTRW'(cnt_q);
  assign top    = mem[top_ix];
  assign depth  = cnt_q;

  always_ff @(posedge clk) begin
    if (push && !full)
      mem[wr_ix] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (push && !full)
      cnt_q <= cnt_q + 1'b1;
    else if (pop && !empty)
      cnt_q <= cnt_q - 1'b1;
  end

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (cnt_q == '0));
  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/vnic_top.sv
module vnic_top
  import vnic_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int PW        = 3,
  parameter int DW        = 32,
  parameter int STK_DEPTH = 8,
  parameter logic [NSRC-1:0] EXT_MASK = 32'hFF00_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_n,
  output logic              fiq_n
);
  localparam int IDXW = $clog2(NSRC);
  localparam int EW   = PW + IDXW;
  localparam int SCW  = $clog2(STK_DEPTH + 1);

  // bus decode
  logic rd_req, wr_req;
  logic ivr_rd, fvr_rd, eoi_wr, en_wr, dis_wr, fset_wr, fclr_wr, spur_wr;
  logic mode_hit, vec_hit;
  logic [IDXW-1:0] rel_idx;

  assign rd_req   = bus_sel & ~bus_wr;
  assign wr_req   = bus_sel & bus_wr;
  assign ivr_rd   = rd_req && (bus_addr == A_IVR);
  assign fvr_rd   = rd_req && (bus_addr == A_FVR);
  assign eoi_wr   = wr_req && (bus_addr == A_EOI);
  assign en_wr    = wr_req && (bus_addr == A_EN);
  assign dis_wr   = wr_req && (bus_addr == A_DIS);
  assign fset_wr  = wr_req && (bus_addr == A_FSET);
  assign fclr_wr  = wr_req && (bus_addr == A_FCLR);
  assign spur_wr  = wr_req && (bus_addr == A_SPUR);
  assign mode_hit = (bus_addr >= A_MODE_BASE) && (bus_addr < A_MODE_BASE + ADDR_W'(NSRC));
  assign vec_hit  = (bus_addr >= A_VEC_BASE) && (bus_addr < A_VEC_BASE + ADDR_W'(NSRC));
  assign rel_idx  = IDXW'(bus_addr);

  // configuration state
  logic [MODE_W-1:0] mode_q [NSRC];
  logic [NSRC-1:0]   mask_q;
  logic [DW-1:0]     spur_q;
  logic              spur_flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) mode_q[i] <= '0;
    end else if (wr_req && mode_hit) begin
      mode_q[rel_idx] <= {bus_wdata[M_LOW] & EXT_MASK[rel_idx], bus_wdata[M_EDGE:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (en_wr)
      mask_q <= mask_q | bus_wdata[NSRC-1:0];
    else if (dis_wr)
      mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      spur_q <= '0;
    else if (spur_wr)
      spur_q <= bus_wdata;
  end

  // per-source conditioning
  logic [NSRC-1:0]    pend, ack, active, enc_act;
  logic [NSRC*PW-1:0] prio_flat;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vnic_src_cond #(.IS_EXT(EXT_MASK[g])) u_cond (
      .clk      (clk),
      .rst      (rst),
      .raw_in   (src_in[g]),
      .edge_mode(mode_q[g][M_EDGE]),
      .low_pol  (mode_q[g][M_LOW]),
      .ack      (ack[g]),
      .fset     (fset_wr & bus_wdata[g]),
      .fclr     (fclr_wr & bus_wdata[g]),
      .pend     (pend[g])
    );
    assign prio_flat[g*PW +: PW] = mode_q[g][PW-1:0];
  end

  assign active  = pend & mask_q;
  assign enc_act = {active[NSRC-1:1], 1'b0};

  // arbitration
  logic            win_valid;
  logic [IDXW-1:0] win_idx;
  logic [PW-1:0]   win_prio;

  vnic_prio_enc #(.NSRC(NSRC), .PW(PW)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .active   (enc_act),
    .prio_flat(prio_flat),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  // level stack
  logic [EW-1:0]  stk_top;
  logic [SCW-1:0] stk_depth;
  logic           stk_empty, stk_full;
  logic           grant, push, pop;
  logic [PW-1:0]  top_prio;
  logic [IDXW-1:0] top_src;

  assign top_prio = stk_top[EW-1 -: PW];
  assign top_src  = stk_top[IDXW-1:0];
  assign grant    = win_valid && (stk_empty || (win_prio > top_prio));
  assign push     = ivr_rd && grant;
  assign pop      = eoi_wr && !spur_flag_q;

  vnic_stack #(.DEPTH(STK_DEPTH), .EW(EW)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  ({win_prio, win_idx}),
    .top  (stk_top),
    .depth(stk_depth),
    .empty(stk_empty),
    .full (stk_full)
  );

  always_comb begin
    ack = '0;
    if (push)   ack[win_idx] = 1'b1;
    if (fvr_rd) ack[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      spur_flag_q <= 1'b0;
    else if (ivr_rd)
      spur_flag_q <= !grant;
    else if (eoi_wr)
      spur_flag_q <= 1'b0;
  end

  // registered request lines
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
      fiq_n <= 1'b1;
    end else begin
      irq_n <= ~grant;
      fiq_n <= ~active[0];
    end
  end

  // vector memory, synchronous read port
  logic [DW-1:0]   vec_mem [NSRC];
  logic [DW-1:0]   vec_rd_q;
  logic [IDXW-1:0] vec_rd_idx;

  always_ff @(posedge clk) begin
    if (wr_req && vec_hit)
      vec_mem[rel_idx] <= bus_wdata;
  end

  always_comb begin
    if (ivr_rd)      vec_rd_idx = win_idx;
    else if (fvr_rd) vec_rd_idx = '0;
    else             vec_rd_idx = rel_idx;
  end

  always_ff @(posedge clk) begin
    vec_rd_q <= vec_mem[vec_rd_idx];
  end

  // read data path
  logic          use_vec_q;
  logic [DW-1:0] other_q, other_d;

  always_comb begin
    other_d = '0;
    if (mode_hit)
      other_d = DW'(mode_q[rel_idx]);
    else begin
      case (bus_addr)
        A_IVR:   other_d = spur_q;
        A_STAT:  other_d = stk_empty ? '0 : DW'(top_src);
        A_PEND:  other_d = DW'(pend);
        A_MASK:  other_d = DW'(mask_q);
        A_SPUR:  other_d = spur_q;
        A_FLAG:  other_d = DW'({~fiq_n, ~irq_n, spur_flag_q});
        default: other_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_vec_q <= 1'b0;
      other_q   <= '0;
    end else if (rd_req) begin
      use_vec_q <= (vec_hit || fvr_rd || push);
      other_q   <= other_d;
    end
  end

  assign bus_rdata = use_vec_q ? vec_rd_q : other_q;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R2
  dis_clr_chk: assert property (@(posedge clk) disable iff (rst)
    dis_wr |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));
  // R9
  spur_nopush_chk: assert property (@(posedge clk) disable iff (rst)
    (ivr_rd && !grant) |=> (stk_depth == $past(stk_depth)));
  // R5
  nest_push_chk: assert property (@(posedge clk) disable iff (rst)
    (ivr_rd && grant && !stk_full) |=> (stk_depth == SCW'($past(stk_depth) + 1'b1)));
  // R3
  fiq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !fiq_n |-> $past(mask_q[0]));
  // R9
  spur_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && spur_flag_q) |=> (stk_depth == $past(stk_depth)));
endmodule

// File: tb/tb_vnic_top.sv
module tb_vnic_top;
  import vnic_pkg::*;

  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam logic [DW-1:0] SPUR_VEC = 32'hDEAD_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_in = '0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            irq_n, fiq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vnic_top dut (
    .clk(clk), .rst(rst), .src_in(src_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  function automatic logic [DW-1:0] vec_of(int i);
    return 32'hA000_0000 + DW'(i) * 16;
  endfunction

  // expected winner among sources 1..NSRC-1, -1 when none
  function automatic int exp_winner(logic [NSRC-1:0] act, int pr[NSRC]);
    int best = -1;
    for (int i = 1; i < NSRC; i++)
      if (act[i] && (best < 0 || pr[i] > pr[best])) best = i;
    return best;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [DW-1:0] d;
    int pr[NSRC];
    int unused_seed;
    unused_seed = $urandom(32'd2024);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", DW'(irq_n), 1);
    chk("R1 fiq_n", DW'(fiq_n), 1);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_PEND, d); chk("R1 pend", d, 0);
    rd(A_STAT, d); chk("R1 stat", d, 0);
    rd(A_FLAG, d); chk("R1 flag", d, 0);

    for (int i = 0; i < NSRC; i++) wr(A_VEC_BASE + ADDR_W'(i), vec_of(i));
    wr(A_SPUR, SPUR_VEC);
    rd(A_VEC_BASE + 7'd13, d); chk("R4 vector readback", d, vec_of(13));

    // R2 atomic mask commands
    wr(A_EN, 32'h0000_00F0);
    wr(A_EN, 32'h0000_0003);
    rd(A_MASK, d); chk("R2 enable", d, 32'h0000_00F3);
    wr(A_DIS, 32'h0000_0010);
    rd(A_MASK, d); chk("R2 disable", d, 32'h0000_00E3);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R11 end-of-interrupt on empty stack
    wr(A_EOI, 0);
    rd(A_STAT, d); chk("R11 stat", d, 0);
    rd(A_FLAG, d); chk("R11 flag", d, 0);

    // R3 fast source
    wr(A_EN, 32'h1);
    src_in[0] = 1'b1;
    wait_cyc(6);
    chk("R3 fiq_n low", DW'(fiq_n), 0);
    chk("R3 irq_n high", DW'(irq_n), 1);
    rd(A_FVR, d); chk("R3 fast vector", d, vec_of(0));
    wr(A_DIS, 32'h1);
    wait_cyc(3);
    chk("R3 fiq_n released", DW'(fiq_n), 1);
    src_in[0] = 1'b0;

    // R12 latency: level reaches irq_n within four cycles
    wr(A_MODE_BASE + 7'd6, 32'h2);
    wr(A_EN, 32'h40);
    @(negedge clk); src_in[6] = 1'b1;
    wait_cyc(4);
    chk("R12 irq_n latency", DW'(irq_n), 0);
    src_in[6] = 1'b0;
    wait_cyc(6);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R5 R6 R9 nesting with a spurious read inside a level
    wr(A_MODE_BASE + 7'd2, 32'h3);
    wr(A_MODE_BASE + 7'd7, 32'h3);
    wr(A_MODE_BASE + 7'd5, 32'h5);
    wr(A_EN, 32'h0000_00A4);
    src_in[2] = 1'b1;
    wait_cyc(6);
    chk("R5 first request", DW'(irq_n), 0);
    rd(A_IVR, d); chk("R4 vector of 2", d, vec_of(2));
    wait_cyc(6);
    chk("R5 served level quiet", DW'(irq_n), 1);
    rd(A_STAT, d); chk("R6 stat 2", d, 2);
    src_in[7] = 1'b1;
    wait_cyc(6);
    chk("R5 equal does not preempt", DW'(irq_n), 1);
    src_in[5] = 1'b1;
    wait_cyc(6);
    chk("R5 higher preempts", DW'(irq_n), 0);
    rd(A_IVR, d); chk("R5 nested vector", d, vec_of(5));
    rd(A_STAT, d); chk("R6 stat 5", d, 5);
    src_in[5] = 1'b0;
    wr(A_EOI, 0);
    wait_cyc(6);
    rd(A_STAT, d); chk("R6 stat after pop", d, 2);
    chk("R5 after pop quiet", DW'(irq_n), 1);
    rd(A_IVR, d); chk("R9 spurious vector", d, SPUR_VEC);
    rd(A_FLAG, d); chk("R9 flag set", d & 1, 1);
    wr(A_EOI, 0);
    rd(A_STAT, d); chk("R9 no pop", d, 2);
    rd(A_FLAG, d); chk("R9 flag cleared", d & 1, 0);
    wr(A_EOI, 0);
    rd(A_STAT, d); chk("R6 stat empty", d, 0);
    wait_cyc(6);
    chk("R5 equals request again", DW'(irq_n), 0);
    rd(A_IVR, d); chk("R4 tie lower number", d, vec_of(2));
    wr(A_EOI, 0);
    src_in[2] = 1'b0; src_in[7] = 1'b0;
    wr(A_DIS, 32'hFFFF_FFFF);
    wait_cyc(6);

    // R7 rising edge latch on source 9
    wr(A_MODE_BASE + 7'd9, 32'h0A);
    wr(A_EN, 32'h200);
    src_in[9] = 1'b1; wait_cyc(2); src_in[9] = 1'b0;
    wait_cyc(6);
    rd(A_PEND, d); chk("R7 edge latched", (d >> 9) & 1, 1);
    chk("R7 edge request", DW'(irq_n), 0);
    rd(A_IVR, d); chk("R7 edge vector", d, vec_of(9));
    wr(A_EOI, 0);
    wait_cyc(6);
    rd(A_PEND, d); chk("R7 edge cleared by read", (d >> 9) & 1, 0);
    chk("R7 edge quiet", DW'(irq_n), 1);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R8 falling edge on external source 30
    src_in[30] = 1'b1;
    wr(A_MODE_BASE + 7'd30, 32'h19);
    wait_cyc(6);
    rd(A_PEND, d); chk("R8 falling no event on high", (d >> 30) & 1, 0);
    src_in[30] = 1'b0;
    wait_cyc(6);
    rd(A_PEND, d); chk("R8 falling latched", (d >> 30) & 1, 1);
    wr(A_EN, 32'h4000_0000);
    wait_cyc(3);
    rd(A_IVR, d); chk("R8 falling vector", d, vec_of(30));
    wr(A_EOI, 0);
    wr(A_DIS, 32'hFFFF_FFFF);

    // R8 active-low level on external source 25
    wr(A_MODE_BASE + 7'd25, 32'h11);
    wait_cyc(3);
    rd(A_PEND, d); chk("R8 low level pending", (d >> 25) & 1, 1);
    src_in[25] = 1'b1;
    wait_cyc(6);
    rd(A_PEND, d); chk("R8 low level idle", (d >> 25) & 1, 0);
    wr(A_MODE_BASE + 7'd25, 32'h0);
    src_in[25] = 1'b0;

    // R8 internal source ignores polarity bit
    wr(A_MODE_BASE + 7'd3, 32'h11);
    rd(A_MODE_BASE + 7'd3, d); chk("R8 internal readback", d, 32'h01);
    wait_cyc(3);
    rd(A_PEND, d); chk("R8 internal stays active-high", (d >> 3) & 1, 0);
    wr(A_MODE_BASE + 7'd3, 32'h0);

    // R10 force set / clear on source 12
    wr(A_MODE_BASE + 7'd12, 32'h4);
    wr(A_FSET, 32'h1000);
    rd(A_PEND, d); chk("R10 forced", (d >> 12) & 1, 1);
    wr(A_FCLR, 32'h1000);
    rd(A_PEND, d); chk("R10 force cleared", (d >> 12) & 1, 0);
    wr(A_FSET, 32'h1000);
    wr(A_EN, 32'h1000);
    wait_cyc(3);
    rd(A_IVR, d); chk("R10 forced vector", d, vec_of(12));
    rd(A_PEND, d); chk("R10 cleared by read", (d >> 12) & 1, 0);
    wr(A_EOI, 0);
    wr(A_DIS, 32'hFFFF_FFFF);
    wr(A_MODE_BASE + 7'd12, 32'h0);

    // R4 random priority rounds on internal sources 1..23
    for (int it = 0; it < 40; it++) begin
      logic [NSRC-1:0] en, lv;
      int w;
      for (int i = 0; i < NSRC; i++) pr[i] = 0;
      for (int i = 1; i < 24; i++) begin
        pr[i] = int'($urandom_range(0, 7));
        wr(A_MODE_BASE + ADDR_W'(i), DW'(pr[i]));
      end
      en = NSRC'($urandom) & 32'h00FF_FFFE;
      lv = NSRC'($urandom) & NSRC'($urandom) & 32'h00FF_FFFE;
      wr(A_DIS, 32'hFFFF_FFFF);
      wr(A_EN, en);
      src_in = lv;
      wait_cyc(6);
      w = exp_winner(en & lv, pr);
      chk("R4 random irq_n", DW'(irq_n), (w < 0) ? 1 : 0);
      rd(A_IVR, d);
      chk("R4 random vector", d, (w < 0) ? SPUR_VEC : vec_of(w));
      rd(A_STAT, d);
      chk("R6 random stat", d, (w < 0) ? 0 : DW'(w));
      wr(A_EOI, 0);
      src_in = '0;
      wait_cyc(4);
    end

    summary();
  end
endmodule